// File: doc/BRIEF.md
# Direct-page bit-test and compare branch sequencer

This block runs the multi-cycle bus sequence of the conditional branches whose condition comes from a byte in the direct page. It handles three families. The first is a branch on one bit of the operand, either when that bit is set or when it is clear, for any of the eight bit positions. The second is a branch when the accumulator differs from the operand, with a plain form and an X-indexed form. The third is a decrement of the memory byte followed by a branch when the result is non-zero. Each bus cycle carries exactly one access: an instruction-stream read at the PC, a direct-page read, a direct-page write, or no access.

The surrounding core pulses `start` with the opcode, the accumulator, the X register and the PC of the byte after the opcode. The sequencer fetches the direct-page address and the signed offset from the instruction stream. It reads the operand and, for the decrement form, writes the result back. It then reports the resulting PC with a one-cycle `done` pulse. The direct-page base is left to the core, so `bus_dp` carries only the 8-bit offset within the page.

Top module: `dpbr_seq`

## Requirements
- R1: While reset is held and in the first cycle after its release, `bus_cmd` is 0 (no access), `done` is 0 and `pc_out` is 0x0000. `bus_cmd` is encoded as 0 for no access, 1 for an instruction read at `bus_pc`, 2 for a direct-page read at `bus_dp`, and 3 for a direct-page write of `bus_wdata` at `bus_dp`.
- R2: An opcode whose low nibble is 3 and whose bit 4 is 0 (0x03, 0x23, ... 0xE3) branches when operand bit `opcode[7:5]` is 1.
- R3: An opcode whose low nibble is 3 and whose bit 4 is 1 (0x13, 0x33, ... 0xF3) branches when operand bit `opcode[7:5]` is 0.
- R4: A bit-test branch issues, one per cycle, an instruction read, a direct-page read, an instruction read and one no-access cycle when it is not taken. When it is taken, two more no-access cycles follow.
- R5: Opcode 0x2E uses the same cycles as R4 and branches exactly when `acc` differs from the operand.
- R6: Opcode 0xDE puts one no-access cycle between the address fetch and the direct-page read, and reads at (address + `xreg`) modulo 256. It branches when `acc` differs from the operand, with R4's cycles after the read.
- R7: Opcode 0x6E does an instruction read, then a direct-page read, then a write of (operand − 1) modulo 256 to the same address, then an instruction read. It then ends if the written value is 0x00. Otherwise it adds two no-access cycles and branches.
- R8: The two instruction reads use `bus_pc` = `pc_in` and then `pc_in`+1, modulo 2^16. A taken branch gives `pc_out` = `pc_in` + 2 + sign-extended offset, modulo 2^16.
- R9: A branch that is not taken gives `pc_out` = `pc_in` + 2 modulo 2^16.
- R10: A `start` with an opcode outside the set in R2–R7 is ignored. So is a `start` while a sequence is running. Neither causes any access or any `done`.
- R11: `done` is high for exactly one cycle, the cycle after the last bus cycle of the sequence. `pc_out` changes only in that cycle and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence with the values below |
| opcode | input | 8 | Opcode of the branch instruction |
| acc | input | 8 | Accumulator value |
| xreg | input | 8 | X register value |
| pc_in | input | 16 | PC of the byte following the opcode |
| bus_rdata | input | 8 | Read data for the current access |
| bus_cmd | output | 2 | Access kind this cycle (encoding in R1) |
| bus_pc | output | 16 | Instruction-stream address |
| bus_dp | output | 8 | Direct-page address |
| bus_wdata | output | 8 | Direct-page write data |
| pc_out | output | 16 | PC after the instruction |
| done | output | 1 | One-cycle completion pulse |

## Verification
The first access appears in the cycle after the clock edge that samples `start`. Each later access follows one cycle after the one before it. `done` and the new `pc_out` appear one cycle after the last access: cycle 5 or 7 for bit tests and 0x2E, cycle 6 or 8 for 0xDE, and cycle 5 or 7 for 0x6E, counting the first access as cycle 1. The bench drives inputs on the falling edge and samples outputs on the falling edge of every cycle. It compares each cycle's access kind and address against a sequence it builds from the requirements. It checks that `done` is high on exactly the predicted cycle and low again on the next one.

// File: rtl/dpbr_pkg.sv
package dpbr_pkg;

    localparam int DW  = 8;
    localparam int PCW = 16;
    localparam int BIW = $clog2(DW);

    typedef enum logic [1:0] {
        BUS_NONE  = 2'd0,
        BUS_RD_PC = 2'd1,
        BUS_RD_DP = 2'd2,
        BUS_WR_DP = 2'd3
    } bus_cmd_e;

    typedef enum logic [1:0] {
        K_BIT  = 2'd0,
        K_CMP  = 2'd1,
        K_CMPX = 2'd2,
        K_DEC  = 2'd3
    } kind_e;

    typedef enum logic [3:0] {
        S_IDLE, S_ADDR, S_XWAIT, S_OPRD, S_WRITE, S_OFS, S_EVAL, S_TK1, S_TK2
    } st_e;

    typedef struct packed {
        logic             valid;
        kind_e            kind;
        logic [BIW-1:0]   bit_idx;
        logic             on_clear;
    } dec_t;

    function automatic dec_t decode_op(input logic [DW-1:0] op);
        dec_t d;
        d.valid    = 1'b1;
        d.kind     = K_BIT;
        d.bit_idx  = op[DW-1 -: BIW];
        d.on_clear = op[4];
        if (op[3:0] == 4'h3)      d.kind = K_BIT;
        else if (op == 8'h2E)     d.kind = K_CMP;
        else if (op == 8'hDE)     d.kind = K_CMPX;
        else if (op == 8'h6E)     d.kind = K_DEC;
        else                      d.valid = 1'b0;
        return d;
    endfunction

endpackage

// File: rtl/dpbr_decode.sv
module dpbr_decode
    import dpbr_pkg::*;
(
    input  logic [DW-1:0] opcode,
    output dec_t          dec
);
    always_comb dec = decode_op(opcode);
endmodule

// File: rtl/dpbr_cond.sv
module dpbr_cond
    import dpbr_pkg::*;
(
    input  kind_e          kind,
    input  logic [BIW-1:0] bit_idx,
    input  logic           on_clear,
    input  logic [DW-1:0]  operand,
    input  logic [DW-1:0]  acc,
    output logic           take
);
    logic [DW-1:0] sel_vec;

    for (genvar i = 0; i < DW; i++) begin : g_sel
        assign sel_vec[i] = (bit_idx == BIW'(i)) && operand[i];
    end

    always_comb begin
        unique case (kind)
            K_BIT:        take = (|sel_vec) ^ on_clear;
            K_CMP, K_CMPX: take = (acc != operand);
            K_DEC:        take = (operand != DW'(1));
            default:      take = 1'b0;
        endcase
    end
endmodule

// File: rtl/dpbr_ctrl.sv
module dpbr_ctrl
    import dpbr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  go,
    input  kind_e kind,
    input  logic  take,
    output st_e   state,
    output logic  last
);
    st_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  nxt = go ? S_ADDR : S_IDLE;
            S_ADDR:  nxt = (kind == K_CMPX) ? S_XWAIT : S_OPRD;
            S_XWAIT: nxt = S_OPRD;
            S_OPRD:  nxt = (kind == K_DEC) ? S_WRITE : S_OFS;
            S_WRITE: nxt = S_OFS;
            S_OFS:   nxt = (kind == K_DEC) ? (take ? S_TK1 : S_IDLE) : S_EVAL;
            S_EVAL:  nxt = take ? S_TK1 : S_IDLE;
            S_TK1:   nxt = S_TK2;
            S_TK2:   nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    assign last = (state != S_IDLE) && (nxt == S_IDLE);

    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/dpbr_seq.sv
module dpbr_seq
    import dpbr_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [7:0]     opcode,
    input  logic [7:0]     acc,
    input  logic [7:0]     xreg,
    input  logic [15:0]    pc_in,
    input  logic [7:0]     bus_rdata,
    output logic [1:0]     bus_cmd,
    output logic [15:0]    bus_pc,
    output logic [7:0]     bus_dp,
    output logic [7:0]     bus_wdata,
    output logic [15:0]    pc_out,
    output logic           done
);
    dec_t           dec;
    st_e            state;
    logic           go, take, last;
    kind_e          kind_q;
    logic [BIW-1:0] bit_q;
    logic           clr_q;
    logic [DW-1:0]  acc_q, x_q, dp_q, opnd_q, ofs_q;
    logic [PCW-1:0] pc_q, pc_seq, pc_br;
    bus_cmd_e       cmd;

    dpbr_decode u_dec (.opcode(opcode), .dec(dec));

    dpbr_cond u_cond (
        .kind(kind_q), .bit_idx(bit_q), .on_clear(clr_q),
        .operand(opnd_q), .acc(acc_q), .take(take)
    );

    assign go = start && dec.valid && (state == S_IDLE);

    dpbr_ctrl u_ctrl (
        .clk(clk), .rst(rst), .go(go), .kind(kind_q),
        .take(take), .state(state), .last(last)
    );

    assign pc_seq = (state == S_OFS) ? pc_q + PCW'(1) : pc_q;
    assign pc_br  = pc_q + {{(PCW-DW){ofs_q[DW-1]}}, ofs_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q <= K_BIT;
            bit_q  <= '0;
            clr_q  <= 1'b0;
            acc_q  <= '0;
            x_q    <= '0;
            dp_q   <= '0;
            opnd_q <= '0;
            ofs_q  <= '0;
            pc_q   <= '0;
            pc_out <= '0;
            done   <= 1'b0;
        end else begin
            done <= last;
            if (last)
                pc_out <= (state == S_TK2) ? pc_br : pc_seq;
            if (go) begin
                kind_q <= dec.kind;
                bit_q  <= dec.bit_idx;
                clr_q  <= dec.on_clear;
                acc_q  <= acc;
                x_q    <= xreg;
                pc_q   <= pc_in;
            end
            unique case (state)
                S_ADDR: begin
                    dp_q <= bus_rdata;
                    pc_q <= pc_q + PCW'(1);
                end
                S_XWAIT: dp_q   <= dp_q + x_q;
                S_OPRD:  opnd_q <= bus_rdata;
                S_OFS: begin
                    ofs_q <= bus_rdata;
                    pc_q  <= pc_q + PCW'(1);
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            S_ADDR, S_OFS: cmd = BUS_RD_PC;
            S_OPRD:        cmd = BUS_RD_DP;
            S_WRITE:       cmd = BUS_WR_DP;
            default:       cmd = BUS_NONE;
        endcase
    end

    assign bus_cmd   = cmd;
    assign bus_pc    = pc_q;
    assign bus_dp    = dp_q;
    assign bus_wdata = opnd_q - DW'(1);
endmodule

// File: rtl/dpbr_seq_chk.sv
module dpbr_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  bus_cmd,
    input logic [7:0]  bus_dp,
    input logic [7:0]  bus_wdata,
    input logic [7:0]  bus_rdata,
    input logic [15:0] pc_out,
    input logic        done
);
    // R7: a write is always preceded by the direct-page read
    a_r7_write_after_read: assert property (@(posedge clk) disable iff (rst)
        bus_cmd == 2'd3 |-> $past(bus_cmd) == 2'd2);

    // R7: write goes back to the address just read
    a_r7_write_same_addr: assert property (@(posedge clk) disable iff (rst)
        bus_cmd == 2'd3 |-> bus_dp == $past(bus_dp));

    // R7: written value is the read value minus one
    a_r7_write_value: assert property (@(posedge clk) disable iff (rst)
        bus_cmd == 2'd3 |-> bus_wdata == $past(bus_rdata) - 8'd1);

    // R11: done lasts a single cycle
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11: pc_out holds outside the done cycle
    a_r11_pc_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(pc_out));

    // R4: the last bus cycle before done is never a direct-page access
    a_r4_last_phase: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(bus_cmd) == 2'd0 || $past(bus_cmd) == 2'd1));
endmodule

bind dpbr_seq dpbr_seq_chk u_chk (
    .clk(clk), .rst(rst), .bus_cmd(bus_cmd), .bus_dp(bus_dp),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pc_out(pc_out), .done(done)
);

// File: tb/dpbr_seq_tb.sv
module dpbr_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00, acc = 8'h00, xreg = 8'h00;
    logic [15:0] pc_in = 16'h0000;
    logic [7:0]  bus_rdata;
    logic [1:0]  bus_cmd;
    logic [15:0] bus_pc, pc_out;
    logic [7:0]  bus_dp, bus_wdata;
    logic        done;

    logic [7:0]  prog [256];
    logic [7:0]  dpm  [256];
    int          n_chk = 0, n_fail = 0, cyc = 0;

    always #2.5 clk = ~clk;

    dpbr_seq u_dut (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode), .acc(acc),
        .xreg(xreg), .pc_in(pc_in), .bus_rdata(bus_rdata), .bus_cmd(bus_cmd),
        .bus_pc(bus_pc), .bus_dp(bus_dp), .bus_wdata(bus_wdata),
        .pc_out(pc_out), .done(done)
    );

    always_comb bus_rdata = (bus_cmd == 2'd1) ? prog[bus_pc[7:0]] : dpm[bus_dp];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (bus_cmd == 2'd3) dpm[bus_dp] <= bus_wdata;
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        wait (cyc > 20000);
        check(1'b0, "WDOG", "watchdog expired", cyc, 20000);
        finish_run();
    end

    // One branch instruction; expected sequence built from R2..R9
    task automatic run_br(input logic [7:0] op, input logic [15:0] pc0,
                          input logic [7:0] dpa, input logic [7:0] opnd,
                          input logic [7:0] ofs, input logic [7:0] a,
                          input logic [7:0] x, input bit poke, input string tag);
        logic [1:0]  exp_seq [10];
        int          len = 0, n = 0;
        bit          taken;
        logic [7:0]  rd_addr;
        logic [15:0] exp_pc, held;
        int          pc_rd = 0;

        rd_addr = (op == 8'hDE) ? dpa + x : dpa;
        if (op[3:0] == 4'h3) taken = op[4] ? !opnd[op[7:5]] : opnd[op[7:5]];
        else if (op == 8'h6E) taken = (opnd - 8'd1) != 8'd0;
        else taken = (a != opnd);

        exp_seq[len++] = 2'd1;
        if (op == 8'hDE) exp_seq[len++] = 2'd0;
        exp_seq[len++] = 2'd2;
        if (op == 8'h6E) exp_seq[len++] = 2'd3;
        exp_seq[len++] = 2'd1;
        if (op != 8'h6E) exp_seq[len++] = 2'd0;
        if (taken) begin exp_seq[len++] = 2'd0; exp_seq[len++] = 2'd0; end
        exp_pc = taken ? pc0 + 16'd2 + {{8{ofs[7]}}, ofs} : pc0 + 16'd2;

        prog[pc0[7:0]] = dpa;
        prog[pc0[7:0] + 8'd1] = ofs;
        dpm[dpa] = ~opnd;
        dpm[rd_addr] = opnd;

        @(negedge clk);
        start = 1'b1; opcode = op; acc = a; xreg = x; pc_in = pc0;
        @(negedge clk);
        for (int c = 0; c < 12; c++) begin
            if (done) break;
            start = 1'b0;
            if (n < len) check(bus_cmd == exp_seq[n], tag, "bus_cmd", bus_cmd, exp_seq[n]);
            else check(1'b0, tag, "extra bus cycle", n, len);
            check(!done, "R11", "done early", done, 0);
            if (bus_cmd == 2'd1) begin
                check(bus_pc == pc0 + 16'(pc_rd), "R8", "pc read address", bus_pc, pc0 + 16'(pc_rd));
                pc_rd++;
            end
            if (bus_cmd == 2'd2 || bus_cmd == 2'd3)
                check(bus_dp == rd_addr, tag, "dp address", bus_dp, rd_addr);
            if (bus_cmd == 2'd3)
                check(bus_wdata == opnd - 8'd1, "R7", "write data", bus_wdata, opnd - 8'd1);
            if (poke && n == 1) begin start = 1'b1; opcode = 8'h03; end // R10 busy start
            n++;
            @(negedge clk);
        end
        start = 1'b0;
        check(done == 1'b1, "R11", "done on predicted cycle", done, 1);
        check(n == len, tag, "cycle count", n, len);
        check(pc_out == exp_pc, taken ? "R8" : "R9", "pc_out", pc_out, exp_pc);
        if (op == 8'h6E)
            check(dpm[dpa] == opnd - 8'd1, "R7", "memory after decrement", dpm[dpa], opnd - 8'd1);
        held = pc_out;
        @(negedge clk);
        check(done == 1'b0, "R11", "done one cycle", done, 0);
        check(pc_out == held, "R11", "pc_out held", pc_out, held);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(bus_cmd == 2'd0, "R1", "bus_cmd in reset", bus_cmd, 0);
        rst = 1'b0;
        @(negedge clk);
        check(bus_cmd == 2'd0, "R1", "bus_cmd after reset", bus_cmd, 0);
        check(done == 1'b0, "R1", "done after reset", done, 0);
        check(pc_out == 16'h0, "R1", "pc_out after reset", pc_out, 0);
    endtask

    task automatic t_invalid(input logic [7:0] op);
        logic [15:0] held;
        held = pc_out;
        @(negedge clk);
        start = 1'b1; opcode = op; pc_in = 16'h4444;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 6; c++) begin
            check(bus_cmd == 2'd0, "R10", "no access for invalid opcode", bus_cmd, 0);
            check(done == 1'b0, "R10", "no done for invalid opcode", done, 0);
            check(pc_out == held, "R10", "pc_out unchanged", pc_out, held);
            @(negedge clk);
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin prog[i] = 8'h00; dpm[i] = 8'h00; end
        t_reset();
        run_br(8'h03, 16'h1200, 8'h40, 8'h01, 8'h10, 8'h00, 8'h00, 1'b0, "R2");
        run_br(8'h03, 16'h1200, 8'h40, 8'hFE, 8'h10, 8'h00, 8'h00, 1'b0, "R2");
        run_br(8'hE3, 16'h2380, 8'h11, 8'h80, 8'hF0, 8'h00, 8'h00, 1'b0, "R2");
        run_br(8'hA3, 16'h2380, 8'h12, 8'hDF, 8'h05, 8'h00, 8'h00, 1'b0, "R2");
        run_br(8'h53, 16'h3000, 8'h21, 8'hFB, 8'h7F, 8'h00, 8'h00, 1'b0, "R3");
        run_br(8'h73, 16'h3000, 8'h22, 8'h08, 8'h7F, 8'h00, 8'h00, 1'b0, "R3");
        run_br(8'hF3, 16'h3050, 8'h23, 8'h7F, 8'h80, 8'h00, 8'h00, 1'b0, "R3");
        run_br(8'h2E, 16'h4000, 8'h30, 8'h55, 8'h08, 8'h56, 8'h00, 1'b0, "R5");
        run_br(8'h2E, 16'h4000, 8'h30, 8'h55, 8'h08, 8'h55, 8'h00, 1'b0, "R5");
        run_br(8'hDE, 16'h5000, 8'hF8, 8'h9A, 8'hFE, 8'h12, 8'h10, 1'b0, "R6");
        run_br(8'hDE, 16'h5000, 8'h20, 8'h9A, 8'hFE, 8'h9A, 8'h03, 1'b0, "R6");
        run_br(8'h6E, 16'h6000, 8'h50, 8'h05, 8'hFC, 8'h00, 8'h00, 1'b0, "R7");
        run_br(8'h6E, 16'h6000, 8'h51, 8'h01, 8'hFC, 8'h00, 8'h00, 1'b0, "R7");
        run_br(8'h6E, 16'h6000, 8'h52, 8'h00, 8'h04, 8'h00, 8'h00, 1'b0, "R7");
        run_br(8'h23, 16'hFFFF, 8'h60, 8'h02, 8'h02, 8'h00, 8'h00, 1'b0, "R8");
        run_br(8'h03, 16'h7000, 8'h70, 8'h01, 8'h20, 8'h00, 8'h00, 1'b1, "R10");
        run_br(8'h03, 16'h7100, 8'h71, 8'h00, 8'h20, 8'h00, 8'h00, 1'b0, "R4");
        t_invalid(8'h2F);
        t_invalid(8'h3E);
        finish_run();
    end
endmodule